// File: doc/BRIEF.md
# Flash Buffered-Program Command Interpreter

This block models the command decoder of a NOR flash device. It covers only the path that programs many words from one buffered sequence. The external bus is reduced to single-cycle write and read strobes, each carrying an address and a 16-bit data word. A host enters the sequence with a setup command aimed at one block. It then writes a word count, a series of data words, and a confirm. The block then reports busy for a fixed number of clock cycles. During that time it copies the captured words into a small internal array.

Reads return either array contents or the status byte, depending on the current read mode. The status byte carries a ready flag and a sticky command-sequence error. Only two things change a read result: the arrival of a new read strobe, and the commands that clear errors or return to array reads.

The controller is a single state machine with six states:
- ST_ARRAY: read-array idle.
- ST_STATUS: read-status idle.
- ST_COUNT: awaiting the word count.
- ST_DATA: capturing buffer words.
- ST_CONFIRM: awaiting the confirm.
- ST_PROG: busy programming.

Its transitions are:
- setup (ST_ARRAY or ST_STATUS to ST_COUNT, on E8h)
- count accept (ST_COUNT to ST_DATA)
- last word (ST_DATA to ST_CONFIRM, when the captured count reaches N)
- confirm (ST_CONFIRM to ST_PROG, on D0h inside the block)
- done (ST_PROG to ST_STATUS, after PROG_CYC cycles)
- abort (ST_COUNT, ST_DATA or ST_CONFIRM to ST_STATUS, setting the error)
- mode select (70h to ST_STATUS, FFh to ST_ARRAY)

Top module: `fbp_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array, rdata is 0000h, and the status byte is 0080h: bit 7 is ready, and bits 5 and 4 (sequence error) are clear.
- R2: A write whose low byte is E8h, made in either idle mode, latches the block (the address bits above the low 8) and selects status reads. A read then returns 0080h.
- R3: The write after setup is always taken as the count N-1 in bits 7:0, even when it is 70h (giving 113 words). A count whose bits 15:8 are non-zero aborts the sequence.
- R4: Exactly N data writes are followed by a write of D0h to the block, which starts programming. Status bit 7 reads 0 for PROG_CYC cycles and then reads 1, with error bits clear (0080h).
- R5: A count, data or confirm write whose address lies outside the latched block aborts the sequence. The status becomes 00B0h and the array is left unchanged.
- R6: A confirm whose low byte is not D0h aborts the sequence with status 00B0h.
- R7: Error bits 5 and 4 stay set through other commands until a write of 50h in an idle mode, which clears them.
- R8: After programming, a write of FFh selects array reads. Each captured address returns its captured word, and when an address repeats, the later write wins.
- R9: While busy, every write is ignored, including FFh and E8h.
- R10: rdata changes only in the cycle after a read strobe. The status shown is the value sampled on that strobe.
- R11: A write of 70h in an idle mode selects status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W | Word address of the write or read |
| wdata | input | DATA_W | Write data or command code |
| rdata | output | DATA_W | Registered read result, updated only after a read strobe |

## Verification
The assertions assume that wr_en and rd_en are never raised in the same cycle. They also assume that PROG_CYC is at least the buffer depth, so that the copy of every word finishes inside the busy window. The stimulus issues each bus write or read as a lone single-cycle strobe, separated by an idle cycle. It draws block numbers, offsets and data from $urandom with a fixed seed, so every data address it forms stays in range, except where a directed case deliberately steps outside the block. The bench always waits out the full busy window before it expects the ready state.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY   = 3'd0,
        ST_STATUS  = 3'd1,
        ST_COUNT   = 3'd2,
        ST_DATA    = 3'd3,
        ST_CONFIRM = 3'd4,
        ST_PROG    = 3'd5
    } fbp_state_e;

    localparam logic [7:0] CMD_SETUP   = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_CLRSR   = 8'h50;
    localparam logic [7:0] CMD_RDSR    = 8'h70;
    localparam logic [7:0] CMD_RDARR   = 8'hFF;

    localparam int SR_READY  = 7;
    localparam int SR_ERR_HI = 5;
    localparam int SR_ERR_LO = 4;

endpackage

// File: rtl/fbp_status.sv
module fbp_status
    import fbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_err,
    input  logic       clr_err,
    input  logic       ready,
    output logic [7:0] sr
);

    logic err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (set_err) begin
            err_q <= 1'b1;
        end else if (clr_err) begin
            err_q <= 1'b0;
        end
    end

    always_comb begin
        sr            = 8'h00;
        sr[SR_READY]  = ready;
        sr[SR_ERR_HI] = err_q;
        sr[SR_ERR_LO] = err_q;
    end

endmodule

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ADDR_W-1:0] addr_mem [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            addr_mem[widx] <= waddr;
            data_mem[widx] <= wdata;
        end
    end

    assign raddr = addr_mem[ridx];
    assign rdata = data_mem[ridx];

endmodule

// File: rtl/fbp_array.sv
module fbp_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fbp_cmd_ctrl.sv
module fbp_cmd_ctrl
    import fbp_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int BLK_OFS_W = 8,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int PROG_CYC  = 260
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int BLK_W = ADDR_W - BLK_OFS_W;
    localparam int TMR_W = $clog2(PROG_CYC + 1);

    fbp_state_e        state_q, state_nx;
    logic [BLK_W-1:0]  blk_q;
    logic [CNT_W-1:0]  last_q;
    logic [CNT_W-1:0]  idx_q;
    logic [TMR_W-1:0]  tmr_q;

    logic              in_blk;
    logic [7:0]        cmd;
    logic              set_err, clr_err;
    logic              latch_blk, latch_cnt, buf_we, tmr_clr;
    logic              ready;
    logic [7:0]        sr;
    logic              arr_we;
    logic [ADDR_W-1:0] buf_raddr;
    logic [DATA_W-1:0] buf_rdata;
    logic [DATA_W-1:0] arr_rdata;

    assign in_blk = (addr[ADDR_W-1:BLK_OFS_W] == blk_q);
    assign cmd    = wdata[7:0];
    assign ready  = (state_q != ST_PROG);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARRAY;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state and control strobes
    always_comb begin
        state_nx  = state_q;
        set_err   = 1'b0;
        clr_err   = 1'b0;
        latch_blk = 1'b0;
        latch_cnt = 1'b0;
        buf_we    = 1'b0;
        tmr_clr   = 1'b0;
        unique case (state_q)
            ST_ARRAY, ST_STATUS: begin
                if (wr_en) begin
                    unique case (cmd)
                        CMD_SETUP: begin
                            latch_blk = 1'b1;
                            state_nx  = ST_COUNT;
                        end
                        CMD_CLRSR: clr_err  = 1'b1;
                        CMD_RDSR:  state_nx = ST_STATUS;
                        CMD_RDARR: state_nx = ST_ARRAY;
                        default:   state_nx = state_q;
                    endcase
                end
            end
            ST_COUNT: begin
                if (wr_en) begin
                    if (!in_blk || (wdata[DATA_W-1:8] != '0)) begin
                        set_err  = 1'b1;
                        state_nx = ST_STATUS;
                    end else begin
                        latch_cnt = 1'b1;
                        state_nx  = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (wr_en) begin
                    if (!in_blk) begin
                        set_err  = 1'b1;
                        state_nx = ST_STATUS;
                    end else begin
                        buf_we = 1'b1;
                        if (idx_q == last_q) begin
                            state_nx = ST_CONFIRM;
                        end
                    end
                end
            end
            ST_CONFIRM: begin
                if (wr_en) begin
                    if (in_blk && (cmd == CMD_CONFIRM)) begin
                        tmr_clr  = 1'b1;
                        state_nx = ST_PROG;
                    end else begin
                        set_err  = 1'b1;
                        state_nx = ST_STATUS;
                    end
                end
            end
            ST_PROG: begin
                if (tmr_q == TMR_W'(PROG_CYC - 1)) begin
                    state_nx = ST_STATUS;
                end
            end
            default: state_nx = ST_ARRAY;
        endcase
    end

    // Sequence datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            last_q <= '0;
            idx_q  <= '0;
            tmr_q  <= '0;
        end else begin
            if (latch_blk) begin
                blk_q <= addr[ADDR_W-1:BLK_OFS_W];
            end
            if (latch_cnt) begin
                last_q <= wdata[CNT_W-1:0];
                idx_q  <= '0;
            end else if (buf_we) begin
                idx_q <= idx_q + 1'b1;
            end
            if (tmr_clr) begin
                tmr_q <= '0;
            end else if (state_q == ST_PROG) begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    // Copy one buffered word per busy cycle, in capture order
    assign arr_we = (state_q == ST_PROG) && (tmr_q <= TMR_W'(last_q));

    // Read output, refreshed only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (state_q == ST_ARRAY) begin
                rdata <= arr_rdata;
            end else begin
                rdata <= {{(DATA_W-8){1'b0}}, sr};
            end
        end
    end

    fbp_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_err (set_err),
        .clr_err (clr_err),
        .ready   (ready),
        .sr      (sr)
    );

    fbp_wbuf #(
        .IDX_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wbuf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (idx_q),
        .waddr (addr),
        .wdata (wdata),
        .ridx  (tmr_q[CNT_W-1:0]),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    fbp_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (buf_raddr),
        .wdata (buf_rdata),
        .raddr (addr),
        .rdata (arr_rdata)
    );

endmodule

// File: rtl/fbp_cmd_chk.sv
module fbp_cmd_chk
    import fbp_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int PROG_CYC = 260
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input fbp_state_e        state,
    input logic [7:0]        sr
);

    localparam int CW = $clog2(PROG_CYC + 2);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (state == ST_PROG) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    // R10: output holds unless a read strobe was seen
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R4: ready bit low throughout programming
    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |-> !sr[SR_READY]);

    // R4: busy window never runs past PROG_CYC cycles
    a_r4_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |-> (busy_cnt < CW'(PROG_CYC)));

    // R4: busy window lasts exactly PROG_CYC cycles
    a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == ST_PROG) |-> (busy_cnt == CW'(PROG_CYC)));

    // R7: error sticks until a clear-status write
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sr[SR_ERR_HI] && !(wr_en && wdata[7:0] == CMD_CLRSR)) |=> sr[SR_ERR_HI]);

    // R5: a fresh error always lands in status-read idle
    a_r5_abort_to_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr[SR_ERR_HI]) |-> (state == ST_STATUS));

    // R3: the count slot consumes exactly one write
    a_r3_count_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && wr_en) |=> (state != ST_COUNT));

    // R9: a busy cycle can only continue or finish into status mode
    a_r9_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |=> (state == ST_PROG || state == ST_STATUS));

endmodule

bind fbp_cmd_ctrl fbp_cmd_chk #(
    .DATA_W   (DATA_W),
    .PROG_CYC (PROG_CYC)
) u_fbp_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .wdata (wdata),
    .rdata (rdata),
    .state (state_q),
    .sr    (sr)
);

// File: tb/tb_fbp_cmd_ctrl.sv
module tb_fbp_cmd_ctrl;

    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 16;
    localparam int PROG_CYC = 260;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [15:0] mdl [1024];

    always #10 clk = ~clk;

    fbp_cmd_ctrl #(
        .ADDR_W    (ADDR_W),
        .BLK_OFS_W (8),
        .DATA_W    (DATA_W),
        .CNT_W     (8),
        .PROG_CYC  (PROG_CYC)
    ) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    function automatic logic [15:0] sr_val(input bit rdy, input bit err);
        return {8'h00, rdy, 1'b0, err, err, 4'h0};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic program_run(input logic [1:0] blk, input int n, input bit use70,
                               input bit poke_busy);
        logic [9:0]  al [256];
        logic [15:0] dl [256];
        logic [15:0] v;
        wr({blk, 8'($urandom)}, 16'h00E8);
        rd({blk, 8'h00}, v);
        chk("R2 setup selects status", v, sr_val(1'b1, 1'b0));
        wr({blk, 8'($urandom)}, use70 ? 16'h0070 : 16'(n - 1));
        for (int i = 0; i < n; i++) begin
            al[i] = {blk, 8'($urandom)};
            dl[i] = 16'($urandom);
            wr(al[i], dl[i]);
        end
        wr({blk, 8'($urandom)}, 16'h00D0);
        rd({blk, 8'h00}, v);
        chk("R4 busy after confirm", v, sr_val(1'b0, 1'b0));
        if (poke_busy) begin
            wr({blk, 8'h00}, 16'h00FF);
            wr({blk, 8'h00}, 16'h00E8);
        end
        repeat (PROG_CYC + 4) @(negedge clk);
        chk("R10 stale status without read", rdata, sr_val(1'b0, 1'b0));
        rd({blk, 8'h00}, v);
        chk("R4 ready after busy window", v, sr_val(1'b1, 1'b0));
        if (poke_busy) begin
            wr({~blk, 8'h00}, 16'h0001);
            rd({blk, 8'h00}, v);
            chk("R9 writes while busy ignored", v, sr_val(1'b1, 1'b0));
        end
        for (int i = 0; i < n; i++) mdl[al[i]] = dl[i];
        wr(10'h000, 16'h00FF);
        for (int i = 0; i < n; i++) begin
            rd(al[i], v);
            chk("R8 array holds programmed word", v, mdl[al[i]]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [9:0]  known_a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 rdata after reset", rdata, 16'h0000);
        wr(10'h000, 16'h0070);
        rd(10'h000, v);
        chk("R1 status after reset", v, sr_val(1'b1, 1'b0));
        chk("R11 70h selects status", v, 16'h0080);

        // Directed: one word, then full 256-word buffer
        program_run(2'd0, 1, 1'b0, 1'b0);
        program_run(2'd1, 256, 1'b0, 1'b0);
        // R3: 70h in the count slot is a count (113 words)
        program_run(2'd2, 113, 1'b1, 1'b0);
        // R9: writes during busy
        program_run(2'd3, 4, 1'b0, 1'b1);

        // Random runs
        for (int r = 0; r < 6; r++) begin
            program_run(2'($urandom), 1 + int'($urandom_range(0, 15)), 1'b0, 1'b0);
        end

        known_a = 10'h000;
        wr(known_a, 16'h0070);
        wr(known_a, 16'h0050);
        wr(known_a, 16'h00E8);
        wr(known_a, 16'h0000);
        wr(known_a, 16'h1234);
        wr(known_a, 16'h00D0);
        repeat (PROG_CYC + 4) @(negedge clk);
        mdl[known_a] = 16'h1234;

        // R5: count address outside block
        wr(10'h100, 16'h00E8);
        wr(10'h200, 16'h0003);
        rd(10'h100, v);
        chk("R5 count outside block aborts", v, sr_val(1'b1, 1'b1));
        // R7: error survives other commands
        wr(10'h100, 16'h0070);
        rd(10'h100, v);
        chk("R7 error sticky through 70h", v, sr_val(1'b1, 1'b1));
        wr(10'h100, 16'h0050);
        rd(10'h100, v);
        chk("R7 50h clears error", v, sr_val(1'b1, 1'b0));

        // R5: data address outside block, array untouched
        wr(10'h000, 16'h00E8);
        wr(10'h000, 16'h0002);
        wr(known_a, 16'hBEEF);
        wr(10'h3C0, 16'hCAFE);
        rd(10'h000, v);
        chk("R5 data outside block aborts", v, sr_val(1'b1, 1'b1));
        wr(10'h000, 16'h0050);
        wr(10'h000, 16'h00FF);
        rd(known_a, v);
        chk("R5 array unchanged after abort", v, mdl[known_a]);

        // R6: wrong confirm code
        wr(10'h000, 16'h00E8);
        wr(10'h000, 16'h0000);
        wr(known_a, 16'h5555);
        wr(10'h000, 16'h00D1);
        rd(10'h000, v);
        chk("R6 bad confirm aborts", v, sr_val(1'b1, 1'b1));
        wr(10'h000, 16'h0050);

        // R5: confirm to another block
        wr(10'h000, 16'h00E8);
        wr(10'h000, 16'h0000);
        wr(known_a, 16'h6666);
        wr(10'h100, 16'h00D0);
        rd(10'h000, v);
        chk("R5 confirm outside block aborts", v, sr_val(1'b1, 1'b1));
        wr(10'h000, 16'h0050);

        // R3: count with non-zero upper byte
        wr(10'h000, 16'h00E8);
        wr(10'h000, 16'h0100);
        rd(10'h000, v);
        chk("R3 oversize count aborts", v, sr_val(1'b1, 1'b1));
        wr(10'h000, 16'h0050);
        wr(10'h000, 16'h00FF);
        rd(known_a, v);
        chk("R8 array intact after aborts", v, mdl[known_a]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule